// File: doc/BRIEF.md
# Six-Tap Horizontal Half-Sample Interpolator

This block produces the horizontal half-sample luma values of a 4x4 block. For each row it takes nine neighbouring 8-bit reference pixels. It applies the symmetric kernel (1, -5, 20, 20, -5, 1) to the four six-pixel windows that start at offsets 0, 1, 2 and 3. Each result is rounded, clipped to 0..255, and the four results are packed into one 32-bit word.

A block begins with a one-cycle `start` pulse. The block then takes two input beats, and each beat carries two rows. For every beat it filters both rows in parallel and hands them downstream one after the other through a valid/ready port. After the fourth row has been taken it raises `done` for one cycle and waits for the next `start`.

The datapath never handles a negative number. Every sample is raised by 255 before filtering. Afterwards a constant of 32·255 − 16 is removed with a subtraction that saturates at zero. What remains is the rounded sum, or zero when the true sum was below −16.

Top module: `hpel_hfilt6`

## Requirements
- R1: Each output pixel equals clip(((p0 − 5·p1 + 20·p2 + 20·p3 − 5·p4 + p5) + 16) >> 5) to 0..255, where p0..p5 are the six input pixels of its window and the shift is arithmetic.
- R2: In an input row, pixel j occupies bits [8j+7:8j]. Output byte k (bits [8k+7:8k]) is computed from the window that starts at pixel k, for k = 0..3.
- R3: A window whose unrounded sum is below −16 yields 0.
- R4: A window whose rounded sum exceeds 255·32 yields 255. For example, nine pixels of 255 give 0xFFFFFFFF.
- R5: `in_ready` is low after reset and stays low until `start` is seen. After a block completes it is low again until the next `start`.
- R6: `in_pair` bits [71:0] hold the lower row of a beat and bits [143:72] the upper row. The two filtered rows are emitted lower first. Row order across the two beats follows the order in which the beats were accepted.
- R7: `done` is high for exactly one cycle: the cycle after the fourth row of a block is accepted downstream (`out_valid` and `out_ready` both high). It is low at all other times, including after reset.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value in the next cycle.
- R9: `in_ready` and `out_valid` are never high in the same cycle.
- R10: A `start` pulse that arrives while a block is in progress is ignored. The block's row count and row order are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a new block when idle |
| in_valid | input | 1 | Input beat available |
| in_ready | output | 1 | Block accepts an input beat |
| in_pair | input | 144 | Two rows of nine pixels each, lower row in bits [71:0] |
| out_valid | output | 1 | Filtered row available |
| out_ready | input | 1 | Downstream takes the row |
| out_data | output | 32 | Four interpolated pixels, leftmost in the low byte |
| done | output | 1 | One-cycle pulse after the last row of a block |

## Verification
The bench builds the block with its default parameters: 8-bit pixels, four outputs per row, two rows per pass and four rows per block. This makes the bias constants equal the real 255 and 8144 and exposes both ends of the clipping range. The blocks include an all-255 image that drives every window to the ceiling, and a pattern that loads only the −5 taps so the sum goes negative. A single-pixel impulse shows which output byte each window lands in. Random downstream stalls, gaps in the input beats, and a `start` pulse sent mid-block exercise holding, ordering and restart gating.

// File: rtl/hpel_pkg.sv
package hpel_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_EMIT = 2'd2
    } hpel_state_e;

endpackage

// File: rtl/hpel_tap6.sv
module hpel_tap6 #(
    parameter int PIX_W = 8
) (
    input  logic [6*PIX_W-1:0] win,
    output logic [PIX_W-1:0]   pel
);
    localparam int SUM_W = PIX_W + 8;
    localparam int BIAS  = (1 << PIX_W) - 1;
    localparam int RM    = 32 * BIAS - 16;
    localparam int CAP   = (1 << (PIX_W + 5)) - 1;

    logic [SUM_W-1:0] b [6];
    logic [SUM_W-1:0] pos_s, neg_s, biased, net, capped;

    always_comb begin
        for (int i = 0; i < 6; i++) begin
            b[i] = SUM_W'(win[i*PIX_W +: PIX_W]) + SUM_W'(BIAS);
        end
        pos_s  = b[0] + b[5] + (b[2] + b[3]) * SUM_W'(20);
        neg_s  = (b[1] + b[4]) * SUM_W'(5);
        biased = pos_s - neg_s;
        net    = (biased > SUM_W'(RM)) ? biased - SUM_W'(RM) : '0;
        capped = (net > SUM_W'(CAP)) ? SUM_W'(CAP) : net;
        pel    = PIX_W'(capped >> 5);
    end
endmodule

// File: rtl/hpel_row.sv
module hpel_row #(
    parameter int PIX_W = 8,
    parameter int OUT_N = 4
) (
    input  logic [(OUT_N+5)*PIX_W-1:0] row_in,
    output logic [OUT_N*PIX_W-1:0]     row_out
);
    genvar k;
    generate
        for (k = 0; k < OUT_N; k++) begin : g_win
            hpel_tap6 #(.PIX_W(PIX_W)) u_tap (
                .win (row_in[k*PIX_W +: 6*PIX_W]),
                .pel (row_out[k*PIX_W +: PIX_W])
            );
        end
    endgenerate
endmodule

// File: rtl/hpel_hfilt6.sv
module hpel_hfilt6 #(
    parameter int PIX_W          = 8,
    parameter int OUT_PER_ROW    = 4,
    parameter int ROWS_PER_PASS  = 2,
    parameter int ROWS_PER_BLOCK = 4
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     start,
    input  logic                                     in_valid,
    output logic                                     in_ready,
    input  logic [ROWS_PER_PASS*(OUT_PER_ROW+5)*PIX_W-1:0] in_pair,
    output logic                                     out_valid,
    input  logic                                     out_ready,
    output logic [OUT_PER_ROW*PIX_W-1:0]             out_data,
    output logic                                     done
);
    import hpel_pkg::*;

    localparam int ROW_IN_W  = (OUT_PER_ROW + 5) * PIX_W;
    localparam int ROW_OUT_W = OUT_PER_ROW * PIX_W;
    localparam int PASSES    = ROWS_PER_BLOCK / ROWS_PER_PASS;
    localparam int ROW_CW    = (ROWS_PER_PASS > 1) ? $clog2(ROWS_PER_PASS) : 1;
    localparam int PASS_CW   = (PASSES > 1) ? $clog2(PASSES) : 1;

    typedef struct packed {
        hpel_state_e                             state;
        logic [ROWS_PER_PASS-1:0][ROW_OUT_W-1:0] res;
        logic [ROW_CW-1:0]                       row;
        logic [PASS_CW-1:0]                      pass;
        logic                                    done;
    } hpel_regs_t;

    hpel_regs_t r_d, r_q;
    logic [ROWS_PER_PASS-1:0][ROW_OUT_W-1:0] filt;

    genvar g;
    generate
        for (g = 0; g < ROWS_PER_PASS; g++) begin : g_lane
            hpel_row #(.PIX_W(PIX_W), .OUT_N(OUT_PER_ROW)) u_row (
                .row_in  (in_pair[g*ROW_IN_W +: ROW_IN_W]),
                .row_out (filt[g])
            );
        end
    endgenerate

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.state = ST_LOAD;
                    r_d.pass  = '0;
                end
            end
            ST_LOAD: begin
                if (in_valid) begin
                    r_d.res   = filt;
                    r_d.row   = '0;
                    r_d.state = ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (out_ready) begin
                    if (r_q.row == ROW_CW'(ROWS_PER_PASS - 1)) begin
                        r_d.row = '0;
                        if (r_q.pass == PASS_CW'(PASSES - 1)) begin
                            r_d.state = ST_IDLE;
                            r_d.done  = 1'b1;
                        end else begin
                            r_d.pass  = r_q.pass + 1'b1;
                            r_d.state = ST_LOAD;
                        end
                    end else begin
                        r_d.row = r_q.row + 1'b1;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_ready  = (r_q.state == ST_LOAD);
    assign out_valid = (r_q.state == ST_EMIT);
    assign out_data  = r_q.res[r_q.row];
    assign done      = r_q.done;

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid)); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(out_valid && out_ready)); // R7
    AST_ACCEPT_THEN_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && !in_ready)); // R6
    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!in_ready && !out_valid)); // R5
endmodule

// File: tb/hpel_hfilt6_tb.sv
module hpel_hfilt6_tb;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [143:0] in_pair = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [31:0]  out_data;
    logic         done;

    int checks = 0;
    int errors = 0;
    logic [7:0]  pix [4][9];
    logic [31:0] expq [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    hpel_hfilt6 u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .in_valid(in_valid), .in_ready(in_ready), .in_pair(in_pair),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [71:0] pack_row(input int r);
        logic [71:0] v;
        for (int j = 0; j < 9; j++) v[8*j +: 8] = pix[r][j];
        return v;
    endfunction

    function automatic logic [31:0] ref_row(input logic [71:0] v);
        logic [31:0] w;
        for (int k = 0; k < 4; k++) begin
            int p [6];
            int s;
            for (int t = 0; t < 6; t++) p[t] = int'(v[8*(k+t) +: 8]);
            s = p[0] - 5*p[1] + 20*p[2] + 20*p[3] - 5*p[4] + p[5];
            s = (s + 16) >>> 5;
            if (s < 0) s = 0;
            if (s > 255) s = 255;
            w[8*k +: 8] = 8'(s);
        end
        return w;
    endfunction

    task automatic fill(input int kind);
        for (int r = 0; r < 4; r++) begin
            for (int j = 0; j < 9; j++) begin
                case (kind)
                    0: pix[r][j] = 8'($urandom);
                    1: pix[r][j] = ((j % 3) == 1) ? 8'd255 : 8'd0;
                    2: pix[r][j] = 8'd255;
                    3: pix[r][j] = (j == 2) ? 8'd100 : 8'd0;
                    default: pix[r][j] = 8'(j * 28 + r * 5);
                endcase
            end
        end
    endtask

    task automatic run_block(input int kind, input bit stall, input bit busy_start);
        int  sent = 0;
        int  seen = 0;
        bit  exp_done = 1'b0;
        bit  stall_prev = 1'b0;
        logic [31:0] stall_data = '0;
        int  p;
        fill(kind);
        if (kind == 1) chk(ref_row(pack_row(0))[7:0] == 8'd0, "R3 model", ref_row(pack_row(0)), 32'h0);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (1) begin
            @(negedge clk);
            start    = busy_start && (seen == 1);
            in_valid = (sent < 2) && (($urandom % 4) != 0);
            p        = (sent < 2) ? sent : 1;
            in_pair  = {pack_row(2*p+1), pack_row(2*p)};
            out_ready = stall ? (($urandom % 3) == 0) : 1'b1;
            #1;
            chk(done == exp_done, "R7 done timing", 32'(done), 32'(exp_done));
            chk(!(in_ready && out_valid), "R9 overlap", {in_ready, out_valid}, 32'h0);
            if (stall_prev) begin
                chk(out_valid == 1'b1, "R8 valid held", 32'(out_valid), 32'h1);
                chk(out_data == stall_data, "R8 data held", out_data, stall_data);
            end
            if (done) break;
            exp_done   = 1'b0;
            stall_prev = 1'b0;
            if (in_valid && in_ready) begin
                expq.push_back(ref_row(pack_row(2*p)));
                expq.push_back(ref_row(pack_row(2*p+1)));
                sent++;
            end
            if (out_valid) begin
                if (out_ready) begin
                    logic [31:0] e;
                    e = (expq.size() > 0) ? expq.pop_front() : 32'hDEADBEEF;
                    chk(out_data == e, "R1 R2 R6 row value/order", out_data, e);
                    if (kind == 2) chk(out_data == 32'hFFFFFFFF, "R4 ceiling", out_data, 32'hFFFFFFFF);
                    if (kind == 1 && (seen % 2) == 0) chk(out_data[7:0] == 8'h00, "R3 negative floor", out_data, 32'h0);
                    if (kind == 3) chk(out_data == 32'h0003003F, "R2 byte placement", out_data, 32'h0003003F);
                    seen++;
                    exp_done = (seen == 4);
                end else begin
                    stall_prev = 1'b1;
                    stall_data = out_data;
                end
            end
        end
        chk(seen == 4, "R6 R10 row count", 32'(seen), 32'd4);
        start    = 1'b0;
        in_valid = 1'b1;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            #1;
            chk(!in_ready && !out_valid, "R5 gated after block", {in_ready, out_valid}, 32'h0);
            chk(!done, "R7 single pulse", 32'(done), 32'h0);
        end
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!in_ready && !out_valid && !done, "R5 R7 reset state", {in_ready, out_valid, done}, 32'h0);
        rst_n = 1'b1;
        in_valid = 1'b1;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            #1;
            chk(!in_ready, "R5 no accept before start", 32'(in_ready), 32'h0);
        end
        in_valid = 1'b0;
        run_block(3, 1'b0, 1'b0);
        run_block(2, 1'b1, 1'b0);
        run_block(1, 1'b0, 1'b0);
        run_block(4, 1'b1, 1'b1);
        for (int b = 0; b < 20; b++) run_block(0, b[0], b[1] & b[2]);
        chk(expq.size() == 0, "R6 queue drained", 32'(expq.size()), 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule